// File: doc/BRIEF.md
# Byte-Programmed Down-Counter Channel

This block is one channel of a counter/timer peripheral. A host writes bytes to it over an 8-bit data bus. Each byte is qualified by a chip select, a write strobe and a channel select. The channel works out what each byte means from two things: bit 0 of the byte, and a one-bit write-sequence state. A byte whose bit 0 is 1 is a control word. A byte whose bit 0 is 0 is an interrupt vector word. The exception is a byte that arrives while the channel is waiting for a time constant: that byte is taken as the time constant whatever its bit 0.

Once a time constant is loaded, the channel counts rising edges of an external trigger. The trigger is first passed through a synchronizer. The counter is reloadable: when it reaches zero it reloads the time constant, pulses its zero-count output for one clock and, if interrupts are enabled, pulses its interrupt request. The stored vector bits are presented on a vector output, with the channel number placed in the low bits. A host's interrupt logic can use this byte when it acknowledges the request.

The write port has no back-pressure. Every qualified write is accepted on the clock edge that samples it, and no ready signal exists. The trigger, zero-count and interrupt pins are plain level signals.

Top module: `dcnt_channel`

## Requirements
- R1: After reset, zero-count out and interrupt request out are 0. Vector out reads 0 in bits 7:3, the channel number (parameter CHAN_ID, default 2) in bits 2:1, and 0 in bit 0. With the defaults this is 8'h04.
- R2: A qualified write in the idle sequence state with bit 0 = 1 is a control word. Its bit 7 sets (1) or clears (0) the channel's interrupt enable.
- R3: A control word with bit 2 = 1 makes the next qualified write the time constant, whatever that byte's bit 0. After that write the sequence returns to idle.
- R4: When no time constant is pending, a qualified write with bit 0 = 0 stores its bits 7:3 as the vector. Vector out shows them one clock later. The written bits 2:1 are ignored and replaced by the channel number, and bit 0 reads 0.
- R5: A write is qualified only when chip select, write strobe and a channel select equal to CHAN_ID are all high in the same cycle. Any other write changes neither the sequence state, the interrupt enable nor the vector.
- R6: In counter mode each rising trigger edge decrements the count. The edge that takes the count from 1 to zero reloads the time constant and raises zero-count out for exactly one clock. A time constant of N therefore gives one pulse every N trigger edges.
- R7: A time constant of 0 counts 256 edges per zero-count pulse.
- R8: Interrupt request out pulses in the same clock as zero-count out when the interrupt enable is set, and stays 0 when it is clear.
- R9: After reset, no trigger activity produces a zero-count pulse until a time constant has been loaded.
- R10: Loading a time constant restarts the count from the new value, discarding any partial count. If the load and a trigger edge fall in the same cycle, the load wins.
- R11: While a time constant is pending, writes for other channels neither consume nor cancel the pending state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select for the peripheral |
| bus_wr | input | 1 | Write strobe, one byte per cycle it is high |
| bus_chan | input | CH_W | Channel select of the write |
| bus_data | input | 8 | Written byte |
| trig_in | input | 1 | External trigger, asynchronous to clk |
| zero_pulse | output | 1 | One-clock pulse when the count reaches zero |
| irq_req | output | 1 | One-clock interrupt request pulse |
| vec_out | output | 8 | Stored vector bits with the channel number inserted |

## Verification
A qualified write changes the channel's state on the edge that samples it, so vector out reflects a vector write one clock later. A rising trigger level first sampled at clock edge k reaches the counter through SYNC_STAGES synchronizer flops. Any zero-count and interrupt pulse it causes is therefore visible after edge k+SYNC_STAGES. The bench models the channel with a history queue of trigger samples and plain integers, updated on every rising edge from the same sampled inputs. It compares all three outputs at the following falling edge. Windowed pulse counts are read only after the synchronizer has drained.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int BYTE_W   = 8;
  localparam int KIND_BIT = 0;  // 1 = control word, 0 = vector word
  localparam int TCF_BIT  = 2;  // control: time constant follows
  localparam int IE_BIT   = 7;  // control: interrupt on zero

  typedef enum logic [0:0] {
    SEQ_IDLE    = 1'b0,
    SEQ_WAIT_TC = 1'b1
  } seq_state_t;
endpackage

// File: rtl/dcnt_wr_seq.sv
module dcnt_wr_seq
  import dcnt_pkg::*;
#(
  parameter int CH_W    = 2,
  parameter int CHAN_ID = 2,
  parameter int VEC_LO  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_cs,
  input  logic                     bus_wr,
  input  logic [CH_W-1:0]          bus_chan,
  input  logic [BYTE_W-1:0]        bus_data,
  output logic                     tc_load,
  output logic [BYTE_W-1:0]        tc_value,
  output logic                     int_en,
  output logic [BYTE_W-1:VEC_LO]   vec_hi
);
  localparam logic [CH_W-1:0] MY_CHAN = CH_W'(CHAN_ID);

  seq_state_t                state_q;
  logic                      ie_q;
  logic [BYTE_W-1:VEC_LO]    vec_q;
  logic                      own_wr;
  logic                      ctl_wr;
  logic                      vec_wr;

  always_comb begin
    own_wr  = bus_cs && bus_wr && (bus_chan == MY_CHAN);
    tc_load = own_wr && (state_q == SEQ_WAIT_TC);
    ctl_wr  = own_wr && (state_q == SEQ_IDLE) && bus_data[KIND_BIT];
    vec_wr  = own_wr && (state_q == SEQ_IDLE) && !bus_data[KIND_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ie_q    <= 1'b0;
      vec_q   <= '0;
    end else begin
      if (tc_load) begin
        state_q <= SEQ_IDLE;
      end else if (ctl_wr) begin
        ie_q    <= bus_data[IE_BIT];
        state_q <= bus_data[TCF_BIT] ? SEQ_WAIT_TC : SEQ_IDLE;
      end else if (vec_wr) begin
        vec_q   <= bus_data[BYTE_W-1:VEC_LO];
      end
    end
  end

  assign tc_value = bus_data;
  assign int_en   = ie_q;
  assign vec_hi   = vec_q;

  AST_TCF_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_data[TCF_BIT]) |=> (state_q == SEQ_WAIT_TC)); // R3
  AST_TC_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    tc_load |=> (state_q == SEQ_IDLE)); // R3
  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !own_wr |=> ($stable(vec_q) && $stable(ie_q) && $stable(state_q))); // R5
  AST_IE_FROM_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ie_q == $past(bus_data[IE_BIT]))); // R2
endmodule

// File: rtl/dcnt_trig_edge.sv
module dcnt_trig_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic trig_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= trig_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign trig_rise = sync_q[SYNC_STAGES-1] && !prev_q;

  AST_EDGE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> !trig_rise); // R6
endmodule

// File: rtl/dcnt_counter.sv
module dcnt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tc_load,
  input  logic [CNT_W-1:0] tc_value,
  input  logic             int_en,
  input  logic             trig_rise,
  output logic             zero_pulse,
  output logic             irq_req
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W:0]   count_q;
  logic [CNT_W-1:0] tc_q;
  logic             running_q;

  function automatic logic [CNT_W:0] reload_of(input logic [CNT_W-1:0] v);
    return (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q    <= '0;
      tc_q       <= '0;
      running_q  <= 1'b0;
      zero_pulse <= 1'b0;
      irq_req    <= 1'b0;
    end else begin
      zero_pulse <= 1'b0;
      irq_req    <= 1'b0;
      if (tc_load) begin
        tc_q      <= tc_value;
        count_q   <= reload_of(tc_value);
        running_q <= 1'b1;
      end else if (running_q && trig_rise) begin
        if (count_q == ONE) begin
          count_q    <= reload_of(tc_q);
          zero_pulse <= 1'b1;
          irq_req    <= int_en;
        end else begin
          count_q    <= count_q - ONE;
        end
      end
    end
  end

  AST_IRQ_WITH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> zero_pulse); // R8
  AST_ZERO_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pulse |=> !zero_pulse); // R6
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |=> !zero_pulse); // R9
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> (count_q != '0)); // R7
  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pulse |-> (count_q == reload_of(tc_q))); // R6
endmodule

// File: rtl/dcnt_channel.sv
module dcnt_channel
  import dcnt_pkg::*;
#(
  parameter int CH_W        = 2,
  parameter int CHAN_ID     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_wr,
  input  logic [CH_W-1:0]   bus_chan,
  input  logic [BYTE_W-1:0] bus_data,
  input  logic              trig_in,
  output logic              zero_pulse,
  output logic              irq_req,
  output logic [BYTE_W-1:0] vec_out
);
  localparam int VEC_LO = CH_W + 1;
  localparam int CNT_W  = BYTE_W;

  logic                   tc_load;
  logic [BYTE_W-1:0]      tc_value;
  logic                   int_en;
  logic [BYTE_W-1:VEC_LO] vec_hi;
  logic                   trig_rise;

  dcnt_wr_seq #(.CH_W(CH_W), .CHAN_ID(CHAN_ID), .VEC_LO(VEC_LO)) u_seq (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
    .bus_chan(bus_chan), .bus_data(bus_data), .tc_load(tc_load),
    .tc_value(tc_value), .int_en(int_en), .vec_hi(vec_hi)
  );

  dcnt_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_rise(trig_rise)
  );

  dcnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tc_load(tc_load), .tc_value(tc_value),
    .int_en(int_en), .trig_rise(trig_rise), .zero_pulse(zero_pulse),
    .irq_req(irq_req)
  );

  assign vec_out = {vec_hi, CH_W'(CHAN_ID), 1'b0};

  AST_VEC_CHANNEL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_out[VEC_LO-1:1] == CH_W'(CHAN_ID)) && !vec_out[0]); // R4
endmodule

// File: tb/dcnt_channel_test.sv
`timescale 1ns/1ps
module dcnt_channel_test;
  localparam int SYNC = 2;
  localparam int ID   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_chan = 2'd0;
  logic [7:0] bus_data = 8'd0;
  logic       trig_in = 1'b0;
  logic       zero_pulse;
  logic       irq_req;
  logic [7:0] vec_out;

  always #2 clk = ~clk;

  dcnt_channel #(.CH_W(2), .CHAN_ID(ID), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
    .bus_chan(bus_chan), .bus_data(bus_data), .trig_in(trig_in),
    .zero_pulse(zero_pulse), .irq_req(irq_req), .vec_out(vec_out)
  );

  int checks = 0;
  int fails  = 0;
  int zc_seen = 0;
  int irq_seen = 0;
  string phase = "R1";

  // behavioural reference
  bit   hist[$];
  int   m_cnt, m_tc;
  bit   m_run, m_ie, m_wait;
  int   m_vec;
  bit   e_zc, e_irq;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i <= SYNC; i++) hist.push_back(1'b0);
      m_cnt = 0; m_tc = 0; m_run = 0; m_ie = 0; m_wait = 0; m_vec = 0;
      e_zc = 0; e_irq = 0;
    end else begin
      bit rise;
      bit own;
      rise = hist[SYNC-1] && !hist[SYNC];
      hist.push_front(trig_in);
      void'(hist.pop_back());
      own = bus_cs && bus_wr && (bus_chan == ID);
      e_zc = 0; e_irq = 0;
      if (own && m_wait) begin
        m_tc = bus_data; m_cnt = (bus_data == 0) ? 256 : bus_data;
        m_run = 1; m_wait = 0;
      end else begin
        if (m_run && rise) begin
          if (m_cnt == 1) begin
            m_cnt = (m_tc == 0) ? 256 : m_tc;
            e_zc = 1; e_irq = m_ie;
          end else m_cnt--;
        end
        if (own && bus_data[0]) begin
          m_ie = bus_data[7]; m_wait = bus_data[2];
        end else if (own) begin
          m_vec = bus_data[7:3];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int ev;
      ev = (m_vec << 3) | (ID << 1);
      check(zero_pulse == e_zc, {phase, " zero_pulse"}, zero_pulse, e_zc);
      check(irq_req == e_irq, {phase, " irq_req"}, irq_req, e_irq);
      check(vec_out == ev, {phase, " vec_out"}, vec_out, ev);
      if (zero_pulse) zc_seen++;
      if (irq_req) irq_seen++;
    end
  end

  task automatic wr_byte(input logic [1:0] ch, input logic [7:0] d, input bit cs);
    @(negedge clk);
    bus_cs = cs; bus_wr = 1'b1; bus_chan = ch; bus_data = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_wr = 1'b0; bus_data = 8'd0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); trig_in = 1'b1;
      @(negedge clk);
      @(negedge clk); trig_in = 1'b0;
      @(negedge clk);
    end
    repeat (SYNC + 3) @(negedge clk);
  endtask

  task automatic window_start();
    zc_seen = 0; irq_seen = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(zero_pulse == 1'b0, "R1 zero_pulse reset", zero_pulse, 0);
    check(irq_req == 1'b0, "R1 irq_req reset", irq_req, 0);
    check(vec_out == 8'h04, "R1 vec_out reset", vec_out, 8'h04);

    // R9 idle before any time constant
    phase = "R9"; window_start();
    pulses(5);
    check(zc_seen == 0, "R9 no pulses before load", zc_seen, 0);

    // R2 R3: control with interrupt and tc-follows, tc byte has bit0=1
    phase = "R3"; wr_byte(2'(ID), 8'h85, 1'b1); wr_byte(2'(ID), 8'h03, 1'b1);
    window_start(); pulses(9);
    check(zc_seen == 3, "R6 divide by 3", zc_seen, 3);
    check(irq_seen == 3, "R2 interrupt enabled", irq_seen, 3);

    // R4 vector store, bits 2:1 replaced
    phase = "R4"; wr_byte(2'(ID), 8'h3E, 1'b1);
    repeat (2) @(negedge clk);
    check(vec_out == 8'h3C, "R4 vector stored", vec_out, 8'h3C);

    // R5 unqualified writes ignored
    phase = "R5"; wr_byte(2'd1, 8'hF0, 1'b1);
    wr_byte(2'(ID), 8'h05, 1'b0);
    repeat (2) @(negedge clk);
    check(vec_out == 8'h3C, "R5 foreign vector ignored", vec_out, 8'h3C);
    wr_byte(2'(ID), 8'h00, 1'b1);
    repeat (2) @(negedge clk);
    check(vec_out == 8'h04, "R5 cs-low control ignored", vec_out, 8'h04);

    // R8 interrupt disabled, next byte is vector
    phase = "R8"; wr_byte(2'(ID), 8'h01, 1'b1); wr_byte(2'(ID), 8'hAE, 1'b1);
    repeat (2) @(negedge clk);
    check(vec_out == 8'hAC, "R4 vector after plain control", vec_out, 8'hAC);
    window_start(); pulses(6);
    check(zc_seen == 2, "R6 count continues", zc_seen, 2);
    check(irq_seen == 0, "R8 no request when disabled", irq_seen, 0);

    // R7 time constant 0 = 256
    phase = "R7"; wr_byte(2'(ID), 8'h05, 1'b1); wr_byte(2'(ID), 8'h00, 1'b1);
    window_start(); pulses(255);
    check(zc_seen == 0, "R7 no pulse at 255", zc_seen, 0);
    pulses(1);
    check(zc_seen == 1, "R7 pulse at 256", zc_seen, 1);

    // R11 pending tc survives foreign writes
    phase = "R11"; wr_byte(2'(ID), 8'h85, 1'b1);
    wr_byte(2'd0, 8'h10, 1'b1); wr_byte(2'd3, 8'h01, 1'b1);
    wr_byte(2'(ID), 8'h02, 1'b1);
    window_start(); pulses(4);
    check(zc_seen == 2, "R11 tc 2 loaded", zc_seen, 2);
    check(irq_seen == 2, "R8 request with zero", irq_seen, 2);

    // R10 reload restarts the count
    phase = "R10"; wr_byte(2'(ID), 8'h05, 1'b1); wr_byte(2'(ID), 8'h04, 1'b1);
    window_start(); pulses(2);
    wr_byte(2'(ID), 8'h05, 1'b1); wr_byte(2'(ID), 8'h04, 1'b1);
    pulses(3);
    check(zc_seen == 0, "R10 partial count discarded", zc_seen, 0);
    pulses(1);
    check(zc_seen == 1, "R10 pulse after full count", zc_seen, 1);

    // R10 load during continuous triggering
    phase = "R10";
    fork
      pulses(12);
      begin
        repeat (7) @(negedge clk);
        wr_byte(2'(ID), 8'h05, 1'b1); wr_byte(2'(ID), 8'h03, 1'b1);
      end
    join

    finish_run();
  end
endmodule